// File: doc/BRIEF.md
# Shared-Timebase Multi-Channel PWM Generator

This block drives several pulse-width-modulated outputs from one free-running counter. The counter advances on a timer tick that is derived from the 48 MHz system clock. A three-bit base selector picks a 4, 12 or 48 MHz tick rate directly. It can instead pick a 1, 4, 12 or 48 MHz rate that then passes through a programmable divisor. Every channel therefore runs at the same frequency. Each period of a running channel starts at counter zero, and all channels begin their periods in the same cycle.

Each channel holds a compare value V that sets how many counts at the start of a period the output spends low. The output is high for the rest of the period, so V = 0 gives a constantly high output and the largest value leaves exactly one high count. A new value goes into a shadow register and is copied into the active compare register only when the counter rolls over, so a period is never cut short. A newly enabled channel waits for the next rollover before it drives its pin. While it is stopped, its output-enable is low and its pin sits at a fixed idle level.

Software configures the block through a single-cycle write port: an address, a data word and a strobe. The counter width, channel count, divisor width, prescale ratios and idle level are all parameters.

Top module: `pwm_bank`

## Requirements
- R1: After reset the base selector is 2 (48 MHz, undivided) and the divisor is 1. Every channel is disabled with value 0, every `pwm_oe_o` bit is 0 and every `pwm_o` bit is at `IDLE_LVL`.
- R2: The shared counter is W = `CNT_W` bits wide and changes only on a timer tick. A running channel with active value V is low for V ticks starting at counter value 0, then high for the remaining 2^W − V ticks.
- R3: Value 0 keeps a running output high for the whole period. Value 2^W − 1 gives exactly one high tick, in the last count of the period.
- R4: All running channels begin their periods on the same rollover. A running output falls only in the cycle in which the counter reads 0.
- R5: Writing 1 to a channel's enable leaves `pwm_oe_o` low until the next counter rollover, when the output starts at count 0. The start delay never exceeds one full period.
- R6: A value written while a channel runs does not change the current period. It takes effect from the next rollover.
- R7: Base selector values 0, 1 and 2 give a tick every `PRE_4M`, `PRE_12M` and 1 system clocks, and the divisor has no effect on them.
- R8: Base selector values 3, 4, 5 and 6 give a tick every `PRE_1M`, `PRE_4M`, `PRE_12M` and 1 system clocks, multiplied by the divisor D. A divisor register value of 0 means D = 256 (in general 2^`DIV_W`).
- R9: Writing 0 to a channel's enable drops its `pwm_oe_o` and returns its `pwm_o` to `IDLE_LVL` on the clock edge that captures the write. Other channels are unaffected.
- R10: Register addresses are as follows. Address 0 is the base selector in data bits [2:0]. Address 1 is the divisor in bits [`DIV_W`−1:0]. Address 2+2c is the value of channel c in bits [`CNT_W`−1:0]. Address 3+2c is the enable of channel c in bit 0. A base selector write of 7 is ignored and the previous setting is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 48 MHz system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | DAT_W | Register write data |
| pwm_o | output | NCH | PWM output per channel |
| pwm_oe_o | output | NCH | Output-enable per channel, high while the channel runs |

## Verification
The bench builds the block with `CNT_W` = 6 and `NCH` = 3, so a period is 64 ticks instead of 65536. This makes several complete periods per base setting short enough to measure cycle by cycle, including the value-0 and value-63 ends of the range. It keeps the default prescale ratios and an 8-bit divisor. With these settings a divisor of 0 (256) still fits in about 16k cycles per period, and both the bypassed and the divided base settings can be timed exactly. Three channels are enough to check edge alignment between channels whose values differ.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   // Timer base selection; encodings are visible at register address 0.
   typedef enum logic [2:0] {
      BASE_4M      = 3'd0,
      BASE_12M     = 3'd1,
      BASE_48M     = 3'd2,
      BASE_1M_DIV  = 3'd3,
      BASE_4M_DIV  = 3'd4,
      BASE_12M_DIV = 3'd5,
      BASE_48M_DIV = 3'd6
   } base_e;

   localparam int BASE_W     = 3;
   localparam int BASE_LAST  = 6;
   localparam int ADDR_BASE  = 0;
   localparam int ADDR_DIV   = 1;
   localparam int ADDR_CH0   = 2;

   function automatic logic base_uses_div(input base_e b);
      return (b >= BASE_1M_DIV);
   endfunction

endpackage

// File: rtl/pwm_bank_tick.sv
module pwm_bank_tick
   import pwm_bank_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int PRE_1M  = 48,
   parameter int PRE_4M  = 12,
   parameter int PRE_12M = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  base_e            base_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   localparam int PRE_W = $clog2(PRE_1M + 1);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] pre_mod;
   logic             strobe;
   logic [DIV_W:0]   div_q;
   logic [DIV_W:0]   div_eff;
   logic             div_hit;

   // Prescale ratio for the chosen base rate.
   always_comb begin
      unique case (base_i)
         BASE_4M, BASE_4M_DIV:   pre_mod = PRE_W'(PRE_4M);
         BASE_12M, BASE_12M_DIV: pre_mod = PRE_W'(PRE_12M);
         BASE_1M_DIV:            pre_mod = PRE_W'(PRE_1M);
         default:                pre_mod = PRE_W'(1);
      endcase
   end

   assign strobe  = (pre_q >= pre_mod - PRE_W'(1));
   assign div_eff = (div_i == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, div_i};
   assign div_hit = (div_q >= div_eff - (DIV_W+1)'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_q <= '0;
         div_q <= '0;
      end else begin
         pre_q <= strobe ? '0 : pre_q + PRE_W'(1);
         if (strobe) begin
            div_q <= div_hit ? '0 : div_q + (DIV_W+1)'(1);
         end
      end
   end

   assign tick_o = strobe && (!base_uses_div(base_i) || div_hit);

endmodule

// File: rtl/pwm_bank_tbase.sv
module pwm_bank_tbase #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = tick_i && (&cnt_q);

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
   parameter int   CNT_W    = 16,
   parameter logic IDLE_LVL = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             val_we_i,
   input  logic             en_we_i,
   input  logic [CNT_W-1:0] val_i,
   input  logic             en_i,
   input  logic             wrap_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             pwm_o,
   output logic             oe_o
);

   logic [CNT_W-1:0] shadow_q;
   logic [CNT_W-1:0] act_q;
   logic             en_q;
   logic             run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         shadow_q <= '0;
         act_q    <= '0;
         en_q     <= 1'b0;
         run_q    <= 1'b0;
      end else begin
         if (val_we_i) begin
            shadow_q <= val_i;
         end
         if (en_we_i) begin
            en_q <= en_i;
         end
         if (en_we_i && !en_i) begin
            run_q <= 1'b0;
         end else if (wrap_i && en_q) begin
            run_q <= 1'b1;
            act_q <= shadow_q;
         end
      end
   end

   // Low for the first act_q counts, high afterwards.
   assign pwm_o = run_q ? (cnt_i >= act_q) : IDLE_LVL;
   assign oe_o  = run_q;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int   NCH      = 4,
   parameter int   CNT_W    = 16,
   parameter int   DIV_W    = 8,
   parameter int   DAT_W    = (CNT_W > DIV_W) ? CNT_W : DIV_W,
   parameter int   ADDR_W   = $clog2(2*NCH + 2),
   parameter int   PRE_1M   = 48,
   parameter int   PRE_4M   = 12,
   parameter int   PRE_12M  = 4,
   parameter logic IDLE_LVL = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DAT_W-1:0]  wr_data_i,
   output logic [NCH-1:0]    pwm_o,
   output logic [NCH-1:0]    pwm_oe_o
);

   localparam int NREG = 2*NCH + 2;

   // Elaboration-time parameter checks.
   if (NCH < 1) begin : g_bad_nch
      $error("pwm_bank: NCH must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("pwm_bank: CNT_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("pwm_bank: DIV_W must be at least 1");
   end
   if (DAT_W < CNT_W || DAT_W < DIV_W || DAT_W < BASE_W) begin : g_bad_dat
      $error("pwm_bank: DAT_W too narrow");
   end
   if (ADDR_W < $clog2(NREG)) begin : g_bad_addr
      $error("pwm_bank: ADDR_W too narrow for channel count");
   end
   if (PRE_12M < 1 || PRE_4M < PRE_12M || PRE_1M < PRE_4M) begin : g_bad_pre
      $error("pwm_bank: prescale ratios must be ordered and nonzero");
   end

   base_e            base_q;
   logic [DIV_W-1:0] div_q;
   logic             tick;
   logic             wrap;
   logic [CNT_W-1:0] cnt;
   logic             base_we;
   logic             div_we;

   assign base_we = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_BASE));
   assign div_we  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_DIV));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         base_q <= BASE_48M;
         div_q  <= DIV_W'(1);
      end else begin
         if (base_we && (wr_data_i[BASE_W-1:0] <= BASE_W'(BASE_LAST))) begin
            base_q <= base_e'(wr_data_i[BASE_W-1:0]);
         end
         if (div_we) begin
            div_q <= wr_data_i[DIV_W-1:0];
         end
      end
   end

   pwm_bank_tick #(
      .DIV_W   (DIV_W),
      .PRE_1M  (PRE_1M),
      .PRE_4M  (PRE_4M),
      .PRE_12M (PRE_12M)
   ) u_tick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .base_i (base_q),
      .div_i  (div_q),
      .tick_o (tick)
   );

   pwm_bank_tbase #(
      .CNT_W (CNT_W)
   ) u_tbase (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick),
      .cnt_o  (cnt),
      .wrap_o (wrap)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic val_we;
      logic en_we;

      assign val_we = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CH0 + 2*c));
      assign en_we  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CH0 + 2*c + 1));

      pwm_bank_chan #(
         .CNT_W    (CNT_W),
         .IDLE_LVL (IDLE_LVL)
      ) u_chan (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .val_we_i (val_we),
         .en_we_i  (en_we),
         .val_i    (wr_data_i[CNT_W-1:0]),
         .en_i     (wr_data_i[0]),
         .wrap_i   (wrap),
         .cnt_i    (cnt),
         .pwm_o    (pwm_o[c]),
         .oe_o     (pwm_oe_o[c])
      );
   end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
   parameter int   NCH      = 4,
   parameter int   CNT_W    = 16,
   parameter logic IDLE_LVL = 1'b0
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             tick_i,
   input logic [CNT_W-1:0] cnt_i,
   input logic [NCH-1:0]   pwm_i,
   input logic [NCH-1:0]   oe_i,
   input logic [2:0]       base_i
);

   // R2: the shared counter holds its value between ticks.
   a_r2_count_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(cnt_i));

   // R10: the stored base selector never takes the unused encoding.
   a_r10_base_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      base_i <= 3'd6);

   for (genvar c = 0; c < NCH; c++) begin : g_chk
      // R9: a stopped channel sits at the idle level.
      a_r9_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !oe_i[c] |-> (pwm_i[c] == IDLE_LVL));

      // R5: a channel starts only on a period boundary.
      a_r5_start_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(oe_i[c]) |-> (cnt_i == '0));

      // R4: a running output falls only at counter zero.
      a_r4_fall_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($fell(pwm_i[c]) && oe_i[c]) |-> (cnt_i == '0));
   end

endmodule

bind pwm_bank pwm_bank_chk #(
   .NCH      (NCH),
   .CNT_W    (CNT_W),
   .IDLE_LVL (IDLE_LVL)
) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .tick_i (tick),
   .cnt_i  (cnt),
   .pwm_i  (pwm_o),
   .oe_i   (pwm_oe_o),
   .base_i (base_q)
);

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;

   localparam int NCH    = 3;
   localparam int CNT_W  = 6;
   localparam int DIV_W  = 8;
   localparam int DAT_W  = 8;
   localparam int ADDR_W = 3;
   localparam int NCNT   = 1 << CNT_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DAT_W-1:0]  wr_data = '0;
   logic [NCH-1:0]    pwm;
   logic [NCH-1:0]    oe;

   int n_chk  = 0;
   int n_fail = 0;
   int lo [NCH];
   int hi [NCH];
   logic [NCH-1:0] first_s;
   logic [NCH-1:0] last_s;

   always #10 clk = ~clk;

   pwm_bank #(
      .NCH    (NCH),
      .CNT_W  (CNT_W),
      .DIV_W  (DIV_W),
      .DAT_W  (DAT_W),
      .ADDR_W (ADDR_W)
   ) u_pwm_bank (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .pwm_o     (pwm),
      .pwm_oe_o  (oe)
   );

   function automatic int a_val(input int c);
      return 2 + 2*c;
   endfunction

   function automatic int a_en(input int c);
      return 3 + 2*c;
   endfunction

   task automatic check_eq(input string req, input string what,
                           input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic write_reg(input int addr, input int data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = ADDR_W'(addr);
      wr_data = DAT_W'(data);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // Sample p cycles from a period start; optional write at cycle wk.
   task automatic measure(input int p, input int wk, input int waddr, input int wdata);
      for (int c = 0; c < NCH; c++) begin
         lo[c] = 0;
         hi[c] = 0;
      end
      for (int k = 0; k < p; k++) begin
         if (k == wk) begin
            wr_en   = 1'b1;
            wr_addr = ADDR_W'(waddr);
            wr_data = DAT_W'(wdata);
         end else begin
            wr_en = 1'b0;
         end
         for (int c = 0; c < NCH; c++) begin
            if (pwm[c]) hi[c]++;
            else        lo[c]++;
         end
         if (k == 0)     first_s = pwm;
         if (k == p - 1) last_s  = pwm;
         @(negedge clk);
      end
      wr_en = 1'b0;
   endtask

   // Wait for channel ch to start; ref channel (if >= 0) must be at its period start.
   task automatic wait_start(input int ch, input int p, input int refc);
      int   n = 0;
      logic prev = 1'b0;
      while (!oe[ch] && n <= p) begin
         prev = (refc >= 0) ? pwm[refc] : 1'b0;
         @(negedge clk);
         n++;
      end
      check_eq("R5", "start delay within one period", (n <= p) ? 1 : 0, 1);
      if (refc >= 0) begin
         check_eq("R5", "start coincides with ref fall", {prev, pwm[refc]}, 2'b10);
      end
   endtask

   // Align to the next period start of channel ch (nonzero value).
   task automatic sync_fall(input int ch, input int bound, input string req);
      int   n = 0;
      logic prev = pwm[ch];
      logic found = 1'b0;
      while (!found && n < bound) begin
         @(negedge clk);
         n++;
         if (prev && !pwm[ch]) found = 1'b1;
         prev = pwm[ch];
      end
      check_eq(req, "period boundary found", found, 1);
   endtask

   task automatic t_reset;
      check_eq("R1", "oe after reset", oe, 0);
      check_eq("R1", "pwm idle after reset", pwm, 0);
      // Default base 2 / divisor 1: one tick per clock.
      write_reg(a_val(0), 1);
      write_reg(a_en(0), 1);
      wait_start(0, NCNT, -1);
      measure(NCNT, -1, 0, 0);
      check_eq("R1", "default timing ch0 low", lo[0], 1);
      check_eq("R2", "value 1 high count", hi[0], NCNT - 1);
   endtask

   task automatic t_basic;
      write_reg(a_val(0), 0);
      write_reg(a_val(1), 32);
      write_reg(a_val(2), NCNT - 1);
      write_reg(a_en(1), 1);
      sync_fall(1, 3*NCNT, "R5");
      write_reg(a_en(2), 1);
      check_eq("R5", "no start before rollover", oe[2], 0);
      wait_start(2, NCNT, 1);
      measure(NCNT, -1, 0, 0);
      check_eq("R3", "value 0 low", lo[0], 0);
      check_eq("R3", "value 0 high", hi[0], NCNT);
      check_eq("R2", "value 32 low", lo[1], 32);
      check_eq("R2", "value 32 high", hi[1], NCNT - 32);
      check_eq("R3", "max value low", lo[2], NCNT - 1);
      check_eq("R3", "max value high", hi[2], 1);
      check_eq("R4", "aligned period start", first_s[2:1], 2'b00);
      check_eq("R4", "aligned period end", last_s, 3'b111);
   endtask

   task automatic t_dbuf;
      measure(NCNT, 16, a_val(1), 8);
      check_eq("R6", "old value kept this period", lo[1], 32);
      measure(NCNT, -1, 0, 0);
      check_eq("R6", "new value next period", lo[1], 8);
   endtask

   task automatic t_disable;
      write_reg(a_en(2), 0);
      check_eq("R9", "oe drops at once", oe[2], 0);
      check_eq("R9", "pwm idle at once", pwm[2], 0);
      check_eq("R9", "other channel unaffected", oe[1], 1);
   endtask

   task automatic t_bypass;
      write_reg(1, 3);
      write_reg(0, 0);
      sync_fall(1, 3*12*NCNT, "R7");
      measure(12*NCNT, -1, 0, 0);
      check_eq("R7", "base 0 ignores divisor low", lo[1], 8*12);
      check_eq("R7", "base 0 ignores divisor high", hi[1], (NCNT - 8)*12);
      write_reg(0, 7);
      sync_fall(1, 3*12*NCNT, "R10");
      measure(12*NCNT, -1, 0, 0);
      check_eq("R10", "base write 7 ignored", lo[1], 8*12);
   endtask

   task automatic t_divided;
      write_reg(0, 6);
      sync_fall(1, 3*3*NCNT, "R8");
      measure(3*NCNT, -1, 0, 0);
      check_eq("R8", "base 6 div 3 low", lo[1], 8*3);
      check_eq("R8", "base 6 div 3 high", hi[1], (NCNT - 8)*3);
      write_reg(1, 2);
      write_reg(0, 5);
      sync_fall(1, 3*8*NCNT, "R8");
      measure(8*NCNT, -1, 0, 0);
      check_eq("R8", "base 5 div 2 low", lo[1], 8*8);
      write_reg(1, 0);
      write_reg(0, 6);
      sync_fall(1, 3*256*NCNT, "R8");
      measure(256*NCNT, -1, 0, 0);
      check_eq("R8", "divisor 0 means 256 low", lo[1], 8*256);
      check_eq("R3", "value 0 high under divisor", hi[0], 256*NCNT);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_basic();
      t_dbuf();
      t_disable();
      t_bypass();
      t_divided();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule